// File: doc/BRIEF.md
# Huffman Tree Bit-Stream Decoder

The block turns a stream of code bits into a list of characters by walking a Huffman tree. Three structures sit in separate word memories outside the block. The tree memory holds tagged nodes, each a Leaf with a character or a Branch with two child pointers. The input memory holds a singly linked list of one-bit values. The output memory receives a singly linked list of characters. The block reads the tree and the input list through two read ports and builds the output list through one write port.

A job begins with a one-cycle `start` pulse. The pulse carries the tree root pointer, the head of the input list and the first free output address. The block reads the root node once and keeps it. It then follows the input list one node at a time and steps to a child of the current Branch for each bit. When the step lands on a Leaf, the block appends a character node to the output list and goes back to the root. When it reaches the end marker of the input list, it writes a terminating node, raises `done` and reports the list head.

All memory traffic uses valid/ready handshakes, and each memory may stall the block at any time. On a read port, the request (valid plus address) stays asserted and unchanged until ready is high at a clock edge. The memory then drives the node word during the following cycle, and the block samples it at the next edge. On the write port, valid, address and data stay unchanged until ready is high at an edge. The root node must be a Branch.

Top module: `huff_decoder`

## Requirements
- R1: After reset, `busy`, `done`, `bad_code` and all three valid outputs are 0.
- R2: A tree word uses bit 18 as its tag (1 = Leaf, 0 = Branch). A Leaf holds its character in bits 7:0. A Branch holds its first child in bits 17:9 and its second child in bits 8:0. Input bit 0 selects the first child and input bit 1 selects the second.
- R3: An input word uses bit 13 as its tag (1 = Cons, 0 = Nil). Bit 12 is the code bit and bits 11:0 point to the next node. The block visits nodes by following these pointers from `in_head`. It ignores the value and pointer fields of a Nil node.
- R4: Each Leaf reached appends the output word {1, char, addr+1}: tag in bit 18, character in bits 17:10, next pointer in bits 9:0. The word is written at address `out_base`, then at consecutive addresses, all taken modulo 1024, in decode order.
- R5: After each Leaf the walk restarts at the root, so consecutive codes decode independently.
- R6: On reaching a Nil input node, the block writes the all-zero word at the next free output address. It then raises `done` and drives `out_head` equal to `out_base`, and both hold until the next accepted start.
- R7: `bad_code` is 1 with `done` exactly when the input list ended partway down the tree. It is 0 otherwise, and a new job clears it.
- R8: Under back-pressure, a pending read request or write keeps its valid, address and data stable until accepted, and no item is lost or repeated.
- R9: The block ignores a `start` pulse that arrives while `busy` is 1, and the running job completes with its own parameters.
- R10: An empty input list (head node is Nil) produces only the terminating word at `out_base`, with `bad_code` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a job (accepted only while idle) |
| root_ptr | input | 9 | Tree root address |
| in_head | input | 12 | First input list node |
| out_base | input | 10 | First free output address |
| busy | output | 1 | Job in progress |
| done | output | 1 | Last job finished |
| bad_code | output | 1 | Last job ended inside a code |
| out_head | output | 10 | Head of the written output list |
| tree_rd_valid | output | 1 | Tree read request |
| tree_rd_ready | input | 1 | Tree memory accepts request |
| tree_rd_addr | output | 9 | Tree read address |
| tree_rd_data | input | 19 | Tree word, cycle after acceptance |
| in_rd_valid | output | 1 | Input list read request |
| in_rd_ready | input | 1 | Input memory accepts request |
| in_rd_addr | output | 12 | Input read address |
| in_rd_data | input | 14 | Input word, cycle after acceptance |
| out_wr_valid | output | 1 | Output write request |
| out_wr_ready | input | 1 | Output memory accepts write |
| out_wr_addr | output | 10 | Output write address |
| out_wr_data | output | 19 | Output list word |

## Verification
The bench goes after codes of different depths, an input list scattered across memory with a pointer that wraps past 4095, and an output base near 1023 so the addresses wrap to 0. A design that picked the wrong child, or dropped the wrapped pointer bits, would write the wrong characters or addresses. The bench also checks a stream that ends one and two bits into a code, where a block that tracked only the last Leaf would miss `bad_code`. Random stalls on all three ports catch a block that moves its request before acceptance, and a mid-job start pulse catches a block that restarts while busy.

// File: rtl/huff_pkg.sv
package huff_pkg;
  typedef enum logic [1:0] {RD_IDLE, RD_REQ, RD_WAIT} rd_state_e;
  typedef enum logic [2:0] {
    W_IDLE, W_ROOT, W_IN, W_CHILD, W_WCHR, W_WNIL
  } walk_state_e;
endpackage

// File: rtl/huff_rd_port.sv
module huff_rd_port #(
  parameter int AW = 9,
  parameter int DW = 19
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          issue,
  input  logic [AW-1:0] issue_addr,
  output logic          rq_valid,
  input  logic          rq_ready,
  output logic [AW-1:0] rq_addr,
  input  logic [DW-1:0] rd_data,
  output logic          resp_valid,
  output logic [DW-1:0] resp_data
);
  import huff_pkg::*;
  rd_state_e st;
  logic [AW-1:0] addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= RD_IDLE;
      addr_q <= '0;
    end else if (issue) begin
      st     <= RD_REQ;
      addr_q <= issue_addr;
    end else begin
      case (st)
        RD_REQ:  if (rq_ready) st <= RD_WAIT;
        RD_WAIT: st <= RD_IDLE;
        default: st <= RD_IDLE;
      endcase
    end
  end

  assign rq_valid   = (st == RD_REQ);
  assign rq_addr    = addr_q;
  assign resp_valid = (st == RD_WAIT);
  assign resp_data  = rd_data;
endmodule

// File: rtl/huff_out_writer.sv
module huff_out_writer #(
  parameter int AW = 10,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_base,
  input  logic          cmd_valid,
  input  logic          cmd_nil,
  input  logic [CW-1:0] cmd_char,
  output logic          wr_valid,
  input  logic          wr_ready,
  output logic [AW-1:0] wr_addr,
  output logic [AW+CW:0] wr_data,
  output logic          accepted,
  output logic [AW-1:0] head
);
  localparam int NW = 1 + CW + AW;
  logic          pend_q;
  logic [AW-1:0] ptr_q, head_q, ptr_n;
  logic [NW-1:0] data_q;

  assign ptr_n = ptr_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      ptr_q  <= '0;
      head_q <= '0;
      data_q <= '0;
    end else if (load) begin
      pend_q <= 1'b0;
      ptr_q  <= load_base;
      head_q <= load_base;
    end else if (cmd_valid) begin
      pend_q <= 1'b1;
      data_q <= cmd_nil ? '0 : {1'b1, cmd_char, ptr_n};
    end else if (pend_q && wr_ready) begin
      pend_q <= 1'b0;
      ptr_q  <= ptr_n;
    end
  end

  assign wr_valid = pend_q;
  assign wr_addr  = ptr_q;
  assign wr_data  = data_q;
  assign accepted = pend_q && wr_ready;
  assign head     = head_q;
endmodule

// File: rtl/huff_walk_ctrl.sv
module huff_walk_ctrl #(
  parameter int TREE_AW = 9,
  parameter int CHAR_W  = 8,
  parameter int IN_AW   = 12
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic [TREE_AW-1:0]     root_ptr,
  input  logic [IN_AW-1:0]       in_head,
  output logic                   tree_issue,
  output logic [TREE_AW-1:0]     tree_addr,
  input  logic                   tree_resp,
  input  logic [2*TREE_AW:0]     tree_data,
  output logic                   in_issue,
  output logic [IN_AW-1:0]       in_addr,
  input  logic                   in_resp,
  input  logic [IN_AW+1:0]       in_data,
  output logic                   wcmd_valid,
  output logic                   wcmd_nil,
  output logic [CHAR_W-1:0]      wcmd_char,
  input  logic                   w_accepted,
  output logic                   load_out,
  output logic                   busy,
  output logic                   done,
  output logic                   bad_code
);
  import huff_pkg::*;
  localparam int TNW = 1 + 2*TREE_AW;
  localparam int INW = 2 + IN_AW;

  walk_state_e st;
  logic [TREE_AW-1:0] root_l, root_r, cur_l, cur_r;
  logic [IN_AW-1:0]   in_ptr;
  logic               partial, done_q, bad_q;

  logic               t_leaf, i_cons, i_bit;
  logic [TREE_AW-1:0] t_left, t_right;
  logic [IN_AW-1:0]   i_next;

  assign t_leaf  = tree_data[TNW-1];
  assign t_left  = tree_data[2*TREE_AW-1:TREE_AW];
  assign t_right = tree_data[TREE_AW-1:0];
  assign i_cons  = in_data[INW-1];
  assign i_bit   = in_data[IN_AW];
  assign i_next  = in_data[IN_AW-1:0];

  always_comb begin
    tree_issue = 1'b0;
    tree_addr  = root_ptr;
    in_issue   = 1'b0;
    in_addr    = in_ptr;
    wcmd_valid = 1'b0;
    wcmd_nil   = 1'b0;
    wcmd_char  = tree_data[CHAR_W-1:0];
    load_out   = 1'b0;
    case (st)
      W_IDLE: if (start) begin
        tree_issue = 1'b1;
        load_out   = 1'b1;
      end
      W_ROOT: if (tree_resp) in_issue = 1'b1;
      W_IN: if (in_resp) begin
        if (i_cons) begin
          tree_issue = 1'b1;
          tree_addr  = i_bit ? cur_r : cur_l;
        end else begin
          wcmd_valid = 1'b1;
          wcmd_nil   = 1'b1;
        end
      end
      W_CHILD: if (tree_resp) begin
        if (t_leaf) wcmd_valid = 1'b1;
        else        in_issue   = 1'b1;
      end
      W_WCHR: if (w_accepted) in_issue = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= W_IDLE;
      root_l  <= '0;
      root_r  <= '0;
      cur_l   <= '0;
      cur_r   <= '0;
      in_ptr  <= '0;
      partial <= 1'b0;
      done_q  <= 1'b0;
      bad_q   <= 1'b0;
    end else begin
      case (st)
        W_IDLE: if (start) begin
          in_ptr  <= in_head;
          partial <= 1'b0;
          done_q  <= 1'b0;
          bad_q   <= 1'b0;
          st      <= W_ROOT;
        end
        W_ROOT: if (tree_resp) begin
          root_l <= t_left;
          root_r <= t_right;
          cur_l  <= t_left;
          cur_r  <= t_right;
          st     <= W_IN;
        end
        W_IN: if (in_resp) begin
          if (i_cons) begin
            in_ptr <= i_next;
            st     <= W_CHILD;
          end else begin
            st <= W_WNIL;
          end
        end
        W_CHILD: if (tree_resp) begin
          if (t_leaf) begin
            cur_l   <= root_l;
            cur_r   <= root_r;
            partial <= 1'b0;
            st      <= W_WCHR;
          end else begin
            cur_l   <= t_left;
            cur_r   <= t_right;
            partial <= 1'b1;
            st      <= W_IN;
          end
        end
        W_WCHR: if (w_accepted) st <= W_IN;
        W_WNIL: if (w_accepted) begin
          done_q <= 1'b1;
          bad_q  <= partial;
          st     <= W_IDLE;
        end
        default: st <= W_IDLE;
      endcase
    end
  end

  assign busy     = (st != W_IDLE);
  assign done     = done_q;
  assign bad_code = bad_q;
endmodule

// File: rtl/huff_decoder.sv
module huff_decoder #(
  parameter int TREE_AW = 9,
  parameter int CHAR_W  = 8,
  parameter int IN_AW   = 12,
  parameter int OUT_AW  = 10
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  input  logic [TREE_AW-1:0]        root_ptr,
  input  logic [IN_AW-1:0]          in_head,
  input  logic [OUT_AW-1:0]         out_base,
  output logic                      busy,
  output logic                      done,
  output logic                      bad_code,
  output logic [OUT_AW-1:0]         out_head,
  output logic                      tree_rd_valid,
  input  logic                      tree_rd_ready,
  output logic [TREE_AW-1:0]        tree_rd_addr,
  input  logic [2*TREE_AW:0]        tree_rd_data,
  output logic                      in_rd_valid,
  input  logic                      in_rd_ready,
  output logic [IN_AW-1:0]          in_rd_addr,
  input  logic [IN_AW+1:0]          in_rd_data,
  output logic                      out_wr_valid,
  input  logic                      out_wr_ready,
  output logic [OUT_AW-1:0]         out_wr_addr,
  output logic [OUT_AW+CHAR_W:0]    out_wr_data
);
  localparam int TNW = 1 + 2*TREE_AW;
  localparam int INW = 2 + IN_AW;

  logic               t_issue, t_resp, i_issue, i_resp;
  logic [TREE_AW-1:0] t_addr;
  logic [IN_AW-1:0]   i_addr;
  logic [TNW-1:0]     t_data;
  logic [INW-1:0]     i_data;
  logic               wc_valid, wc_nil, w_acc, ld_out;
  logic [CHAR_W-1:0]  wc_char;

  huff_walk_ctrl #(.TREE_AW(TREE_AW), .CHAR_W(CHAR_W), .IN_AW(IN_AW)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .start(start), .root_ptr(root_ptr), .in_head(in_head),
    .tree_issue(t_issue), .tree_addr(t_addr), .tree_resp(t_resp), .tree_data(t_data),
    .in_issue(i_issue), .in_addr(i_addr), .in_resp(i_resp), .in_data(i_data),
    .wcmd_valid(wc_valid), .wcmd_nil(wc_nil), .wcmd_char(wc_char), .w_accepted(w_acc),
    .load_out(ld_out), .busy(busy), .done(done), .bad_code(bad_code)
  );

  huff_rd_port #(.AW(TREE_AW), .DW(TNW)) tree_port_i (
    .clk(clk), .rst_n(rst_n), .issue(t_issue), .issue_addr(t_addr),
    .rq_valid(tree_rd_valid), .rq_ready(tree_rd_ready), .rq_addr(tree_rd_addr),
    .rd_data(tree_rd_data), .resp_valid(t_resp), .resp_data(t_data)
  );

  huff_rd_port #(.AW(IN_AW), .DW(INW)) in_port_i (
    .clk(clk), .rst_n(rst_n), .issue(i_issue), .issue_addr(i_addr),
    .rq_valid(in_rd_valid), .rq_ready(in_rd_ready), .rq_addr(in_rd_addr),
    .rd_data(in_rd_data), .resp_valid(i_resp), .resp_data(i_data)
  );

  huff_out_writer #(.AW(OUT_AW), .CW(CHAR_W)) writer_i (
    .clk(clk), .rst_n(rst_n), .load(ld_out), .load_base(out_base),
    .cmd_valid(wc_valid), .cmd_nil(wc_nil), .cmd_char(wc_char),
    .wr_valid(out_wr_valid), .wr_ready(out_wr_ready), .wr_addr(out_wr_addr),
    .wr_data(out_wr_data), .accepted(w_acc), .head(out_head)
  );
endmodule

// File: rtl/huff_decoder_chk.sv
module huff_decoder_chk #(
  parameter int TREE_AW = 9,
  parameter int CHAR_W  = 8,
  parameter int OUT_AW  = 10
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   start,
  input logic [OUT_AW-1:0]      out_base,
  input logic                   busy,
  input logic                   done,
  input logic                   tree_rd_valid,
  input logic                   tree_rd_ready,
  input logic [TREE_AW-1:0]     tree_rd_addr,
  input logic                   out_wr_valid,
  input logic                   out_wr_ready,
  input logic [OUT_AW-1:0]      out_wr_addr,
  input logic [OUT_AW+CHAR_W:0] out_wr_data
);
  localparam int ONW = 1 + CHAR_W + OUT_AW;
  logic              fire;
  logic [OUT_AW-1:0] exp_addr;

  assign fire = out_wr_valid && out_wr_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                exp_addr <= '0;
    else if (start && !busy)   exp_addr <= out_base;
    else if (fire)             exp_addr <= out_wr_addr + 1'b1;
  end

  // R1: the job flags never overlap
  a_r1_busy_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

  // R4: each written word lands on the next consecutive address
  a_r4_addr_sequence: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> out_wr_addr == exp_addr);

  // R6: terminating word carries no fields
  a_r6_nil_word_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !out_wr_data[ONW-1]) |-> out_wr_data[ONW-2:0] == '0);

  // R6: done rises only after the terminating write was accepted
  a_r6_done_after_nil: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(fire && !out_wr_data[ONW-1]));

  // R8: write held stable under back-pressure
  a_r8_write_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_wr_valid && !out_wr_ready) |=>
      (out_wr_valid && $stable(out_wr_addr) && $stable(out_wr_data)));

  // R8: tree read request held stable under back-pressure
  a_r8_read_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (tree_rd_valid && !tree_rd_ready) |=> (tree_rd_valid && $stable(tree_rd_addr)));
endmodule

bind huff_decoder huff_decoder_chk #(.TREE_AW(TREE_AW), .CHAR_W(CHAR_W), .OUT_AW(OUT_AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .out_base(out_base), .busy(busy), .done(done),
  .tree_rd_valid(tree_rd_valid), .tree_rd_ready(tree_rd_ready), .tree_rd_addr(tree_rd_addr),
  .out_wr_valid(out_wr_valid), .out_wr_ready(out_wr_ready), .out_wr_addr(out_wr_addr),
  .out_wr_data(out_wr_data)
);

// File: tb/huff_decoder_tb_top.sv
module huff_decoder_tb_top;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0, start = 1'b0;
  logic [8:0] root_ptr = '0;
  logic [11:0] in_head = '0;
  logic [9:0] out_base = '0;
  logic busy, done, bad_code;
  logic [9:0] out_head;
  logic tree_rd_valid, tree_rd_ready = 1'b1;
  logic [8:0] tree_rd_addr;
  logic [18:0] tree_rd_data = '0;
  logic in_rd_valid, in_rd_ready = 1'b1;
  logic [11:0] in_rd_addr;
  logic [13:0] in_rd_data = '0;
  logic out_wr_valid, out_wr_ready = 1'b1;
  logic [9:0] out_wr_addr;
  logic [18:0] out_wr_data;

  huff_decoder dut_i (.*);

  logic [18:0] tree_mem [0:511];
  logic [13:0] in_mem [int];
  logic [9:0]  exp_addr [$];
  logic [18:0] exp_data [$];
  bit          bits [$];
  int checks = 0, errors = 0;
  bit stall_en = 0;
  string cur_tag = "R4";
  logic [15:0] lfsr = 16'hACE1;
  bit t_pend = 0, i_pend = 0;
  logic [8:0] t_paddr;
  logic [11:0] i_paddr;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // memory models and output monitor (scoreboard)
  always @(negedge clk) begin
    if (t_pend) begin tree_rd_data = tree_mem[t_paddr]; t_pend = 0; end
    if (i_pend) begin
      in_rd_data = in_mem.exists(int'(i_paddr)) ? in_mem[int'(i_paddr)] : 14'h0;
      i_pend = 0;
    end
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    tree_rd_ready = stall_en ? (lfsr[0] | lfsr[1]) : 1'b1;
    in_rd_ready   = stall_en ? (lfsr[2] | lfsr[3]) : 1'b1;
    out_wr_ready  = stall_en ? (lfsr[4] | lfsr[5]) : 1'b1;
    if (tree_rd_valid && tree_rd_ready) begin t_pend = 1; t_paddr = tree_rd_addr; end
    if (in_rd_valid && in_rd_ready) begin i_pend = 1; i_paddr = in_rd_addr; end
    if (out_wr_valid && out_wr_ready) begin
      if (exp_addr.size() == 0) chk(0, {cur_tag, " extra write"}, int'(out_wr_addr), 0);
      else begin
        logic [9:0] ea;
        logic [18:0] ed;
        ea = exp_addr.pop_front();
        ed = exp_data.pop_front();
        chk(out_wr_addr == ea, {cur_tag, " R4 address"}, int'(out_wr_addr), int'(ea));
        chk(out_wr_data == ed, {cur_tag, " R2 R3 R4 word"}, int'(out_wr_data), int'(ed));
      end
    end
  end

  // code table: A=0 B=10 C=110 D=111
  task automatic add_code(input byte c);
    case (c)
      "A": bits.push_back(0);
      "B": begin bits.push_back(1); bits.push_back(0); end
      "C": begin bits.push_back(1); bits.push_back(1); bits.push_back(0); end
      default: begin bits.push_back(1); bits.push_back(1); bits.push_back(1); end
    endcase
  endtask

  task automatic run_job(input string msg, input int tail, input int head, input int stride,
                         input int base, input bit mid_start, input bit exp_err, input string tag);
    int a, cnt;
    cur_tag = tag;
    bits.delete();
    for (int i = 0; i < msg.len(); i++) add_code(msg[i]);
    for (int i = 0; i < tail; i++) bits.push_back(1);
    in_mem.delete();
    a = head % 4096;
    for (int k = 0; k < bits.size(); k++) begin
      int nx;
      nx = (head + (k + 1) * stride) % 4096;
      in_mem[a] = {1'b1, bits[k], 12'(nx)};
      a = nx;
    end
    in_mem[a] = {1'b0, 1'b1, 12'hABC};  // R3: Nil fields ignored
    for (int i = 0; i < msg.len(); i++) begin
      exp_addr.push_back(10'(base + i));
      exp_data.push_back({1'b1, msg[i], 10'(base + i + 1)});
    end
    exp_addr.push_back(10'(base + msg.len()));
    exp_data.push_back(19'h0);  // R6 terminating word
    @(negedge clk);
    start = 1; root_ptr = 9'd5; in_head = 12'(head); out_base = 10'(base);
    @(negedge clk);
    start = 0;
    if (mid_start) begin  // R9
      repeat (12) @(negedge clk);
      chk(busy == 1'b1, "R9 busy before pulse", int'(busy), 1);
      start = 1; out_base = 10'd500; in_head = 12'd0; root_ptr = 9'd7;
      @(negedge clk);
      start = 0;
    end
    cnt = 0;
    while (!done && cnt < 20000) begin @(negedge clk); cnt++; end
    if (!done) chk(0, {tag, " watchdog"}, 0, 1);
    chk(out_head == 10'(base), {tag, " R6 head"}, int'(out_head), base);
    chk(bad_code == exp_err, {tag, " R7 bad_code"}, int'(bad_code), int'(exp_err));
    chk(exp_addr.size() == 0, {tag, " missing writes"}, exp_addr.size(), 0);
    chk(busy == 1'b0, {tag, " idle after done"}, int'(busy), 0);
    exp_addr.delete();
    exp_data.delete();
  endtask

  initial begin
    for (int i = 0; i < 512; i++) tree_mem[i] = 19'h0;
    tree_mem[5]  = {1'b0, 9'd7,  9'd9};   // root
    tree_mem[7]  = {1'b1, 10'h3FF, 8'h41}; // A
    tree_mem[9]  = {1'b0, 9'd11, 9'd13};
    tree_mem[11] = {1'b1, 10'h0, 8'h42};   // B
    tree_mem[13] = {1'b0, 9'd20, 9'd21};
    tree_mem[20] = {1'b1, 10'h0, 8'h43};   // C
    tree_mem[21] = {1'b1, 10'h0, 8'h44};   // D
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(busy == 0, "R1 busy", int'(busy), 0);
    chk(done == 0, "R1 done", int'(done), 0);
    chk(bad_code == 0, "R1 bad_code", int'(bad_code), 0);
    chk({tree_rd_valid, in_rd_valid, out_wr_valid} == 3'b0, "R1 valids",
        int'({tree_rd_valid, in_rd_valid, out_wr_valid}), 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    run_job("ABCD", 0, 3, 1, 0, 0, 0, "R2 R5");
    run_job("", 0, 40, 1, 77, 0, 0, "R10");
    run_job("AB", 2, 100, 3, 10, 0, 1, "R7 two");
    run_job("DA", 1, 100, 3, 10, 0, 1, "R7 one");
    run_job("DDA", 0, 200, 2, 30, 0, 0, "R7 clear");
    stall_en = 1;
    run_job("DCBAABDC", 0, 4090, 37, 1020, 0, 0, "R8 R3");
    run_job("CABBAD", 0, 600, 5, 300, 1, 0, "R9");
    stall_en = 0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1500000;
    errors++; checks++;
    $display("FAIL global watchdog: actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule